// File: doc/BRIEF.md
# Crypto Register Access-Control Guard

This block tracks a 5-bit access mask for each register of a small crypto register file and rules on every crypto command before it runs. One command is presented per cycle with its opcode, a destination index, a source index, the index of the active key register and a 5-bit immediate. One cycle later the block answers allow or deny. In the same clock edge it updates the destination mask as the opcode requires. For cipher results the new mask is the AND of the key mask and the source mask. Signature encryption forces a fixed mask. A random fill loads a fixed mask, and a secret load takes a per-secret mask from its input.

Refusals that come from a missing permission go into a sticky 32-bit cause register. A summary bit in that register drives the interrupt output, and software clears the causes by writing ones. The block also keeps a saved-signature flag. A signature-authenticate command sets the flag when the external hash engine reports a pass, as long as the block is not already in secure mode. A signature-clear command drops the flag. Signature encryption runs only while the flag is set.

Cipher, hash and random engines lie outside the block. Their verdicts arrive as plain inputs sampled with the command. A monitor port returns the mask of any register.

Top module: `crypto_acl_guard`

## Requirements
- R1: After reset, resp_valid, resp_allow, acl_err, acl_irq and sig_valid are 0, and every register mask reads 0.
- R2: resp_valid is high exactly in the cycle after a cycle with cmd_valid high. resp_allow in that cycle carries the verdict. A cycle without cmd_valid changes no mask, flag or error bit.
- R3: Random fill (opcode 0x04) sets the destination mask to 0x1F. Secret load (opcode 0x13) sets the destination mask to secret_acl, whatever the mask was before. Both are allowed.
- R4: XOR (opcode 0x0B) is allowed only if bit 1 is set in the masks of both cmd_x and cmd_y. A missing bit 1 in cmd_x sets error bit 0 (write fault). A missing bit 1 in cmd_y sets error bit 4 (read fault). XOR never changes a mask.
- R5: Change-mode (opcode 0x0A) is allowed and writes cmd_imm into the mask of cmd_x when cmd_imm has no bit outside that mask. Otherwise it is denied, the mask is kept, and error bit 8 is set.
- R6: Encrypt (opcode 0x14) and decrypt (opcode 0x15) are allowed and set the mask of cmd_x to the AND of the masks of cmd_key and cmd_y.
- R7: Signature-authenticate (opcode 0x16) is denied with secure_mode high, and sig_valid is then unchanged. Otherwise it is allowed. With sig_pass high it sets sig_valid and stores cmd_x in sig_idx. With sig_pass low, sig_valid is unchanged.
- R8: Signature-clear (opcode 0x17) is allowed and clears sig_valid.
- R9: Signature-encrypt (opcode 0x18) with sig_valid set is allowed and sets the mask of cmd_x to 0x13. Without sig_valid it is denied, changes no mask and sets no error bit.
- R10: Error bits 0, 4 and 8 are sticky. A bit is cleared when err_clr_we is high and the matching bit of err_clr_mask is 1. A new fault in the same cycle wins over the clear. Bit 31 equals the OR of bits 0, 4 and 8 after each update, all other bits stay 0, and acl_irq follows bit 31.
- R11: NOP (opcode 0x00) is allowed with no effect. Any opcode not listed here is denied and changes no mask, flag or error bit.
- R12: mon_acl shows, one cycle after mon_idx is presented, the mask that register held at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 5 | Command opcode |
| cmd_x | input | IDXW (3) | Destination / first operand register |
| cmd_y | input | IDXW (3) | Source / second operand register |
| cmd_key | input | IDXW (3) | Active key register for cipher commands |
| cmd_imm | input | 5 | Immediate mask for change-mode |
| secret_acl | input | 5 | Mask of the secret being loaded |
| sig_pass | input | 1 | Hash verification passed |
| secure_mode | input | 1 | Block already runs in secure mode |
| err_clr_we | input | 1 | Write-one-to-clear strobe for the error register |
| err_clr_mask | input | 32 | Bits to clear |
| mon_idx | input | IDXW (3) | Register whose mask is monitored |
| resp_valid | output | 1 | Verdict valid |
| resp_allow | output | 1 | Command allowed |
| acl_err | output | 32 | Sticky error causes and summary bit |
| acl_irq | output | 1 | Access-error interrupt |
| sig_valid | output | 1 | Saved signature present |
| sig_idx | output | IDXW (3) | Register holding the saved signature |
| mon_acl | output | 5 | Monitored mask |

## Verification
On every cycle the assertions check four things. The response follows each command by exactly one cycle. The summary bit agrees with the cause bits, and the reserved bits stay zero. Cause bits persist unless a clear is strobed. Signature-clear, signature-authenticate in secure mode, and signature-encrypt without a saved signature always end in the expected flag or verdict. The directed scenarios show what the mask values should be: inheritance through cipher results, fixed fill and secret values, subset testing for change-mode, and the precedence of a new fault over a clear in the same cycle. Each mask value is read back through the monitor port.

// File: rtl/acl_guard_pkg.sv
package acl_guard_pkg;
  localparam int ACL_W = 5;
  localparam int OP_W  = 5;
  localparam int ERR_W = 32;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 5'h00,
    OP_RND     = 5'h04,
    OP_CHMOD   = 5'h0A,
    OP_XOR     = 5'h0B,
    OP_SECRET  = 5'h13,
    OP_ENC     = 5'h14,
    OP_DEC     = 5'h15,
    OP_SIGAUTH = 5'h16,
    OP_SIGCLR  = 5'h17,
    OP_SIGENC  = 5'h18
  } op_e;

  localparam int ERR_WR_BIT  = 0;
  localparam int ERR_RD_BIT  = 4;
  localparam int ERR_MOD_BIT = 8;
  localparam int ERR_ANY_BIT = 31;
  localparam logic [ERR_W-1:0] CAUSE_MASK =
    (32'h1 << ERR_WR_BIT) | (32'h1 << ERR_RD_BIT) | (32'h1 << ERR_MOD_BIT);

  localparam int ACL_DATA_BIT = 1;
  localparam logic [ACL_W-1:0] ACL_FILL   = 5'h1F;
  localparam logic [ACL_W-1:0] ACL_SIGOUT = 5'h13;

  typedef struct packed {
    logic             allow;
    logic             wr_en;
    logic [ACL_W-1:0] wr_val;
    logic             e_wr;
    logic             e_rd;
    logic             e_mod;
    logic             sig_set;
    logic             sig_clr;
  } verdict_t;
endpackage

// File: rtl/acl_file.sv
module acl_file
  import acl_guard_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDXW-1:0]  waddr,
  input  logic [ACL_W-1:0] wdata,
  input  logic [IDXW-1:0]  ra,
  input  logic [IDXW-1:0]  rb,
  input  logic [IDXW-1:0]  rc,
  output logic [ACL_W-1:0] da,
  output logic [ACL_W-1:0] db,
  output logic [ACL_W-1:0] dc,
  input  logic [IDXW-1:0]  mon_idx,
  output logic [ACL_W-1:0] mon_acl
);
  logic [ACL_W-1:0] mem [NREG];

  assign da = mem[ra];
  assign db = mem[rb];
  assign dc = mem[rc];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      mon_acl <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      mon_acl <= mem[mon_idx];
    end
  end
endmodule

// File: rtl/acl_policy.sv
module acl_policy
  import acl_guard_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [ACL_W-1:0] acl_x,
  input  logic [ACL_W-1:0] acl_y,
  input  logic [ACL_W-1:0] acl_k,
  input  logic [ACL_W-1:0] imm,
  input  logic [ACL_W-1:0] secret_acl,
  input  logic             sig_pass,
  input  logic             secure_mode,
  input  logic             sig_valid,
  output verdict_t         verdict
);
  logic widen;
  assign widen = |(imm & ~acl_x);

  always_comb begin
    verdict = '0;
    case (op)
      OP_NOP: verdict.allow = 1'b1;
      OP_RND: begin
        verdict.allow  = 1'b1;
        verdict.wr_en  = 1'b1;
        verdict.wr_val = ACL_FILL;
      end
      OP_SECRET: begin
        verdict.allow  = 1'b1;
        verdict.wr_en  = 1'b1;
        verdict.wr_val = secret_acl;
      end
      OP_CHMOD: begin
        verdict.allow  = !widen;
        verdict.wr_en  = !widen;
        verdict.wr_val = imm;
        verdict.e_mod  = widen;
      end
      OP_XOR: begin
        verdict.allow = acl_x[ACL_DATA_BIT] & acl_y[ACL_DATA_BIT];
        verdict.e_wr  = !acl_x[ACL_DATA_BIT];
        verdict.e_rd  = !acl_y[ACL_DATA_BIT];
      end
      OP_ENC, OP_DEC: begin
        verdict.allow  = 1'b1;
        verdict.wr_en  = 1'b1;
        verdict.wr_val = acl_k & acl_y;
      end
      OP_SIGAUTH: begin
        verdict.allow   = !secure_mode;
        verdict.sig_set = !secure_mode & sig_pass;
      end
      OP_SIGCLR: begin
        verdict.allow   = 1'b1;
        verdict.sig_clr = 1'b1;
      end
      OP_SIGENC: begin
        verdict.allow  = sig_valid;
        verdict.wr_en  = sig_valid;
        verdict.wr_val = ACL_SIGOUT;
      end
      default: verdict = '0;
    endcase
  end
endmodule

// File: rtl/acl_err_reg.sv
module acl_err_reg
  import acl_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_wr,
  input  logic             set_rd,
  input  logic             set_mod,
  input  logic             clr_we,
  input  logic [ERR_W-1:0] clr_mask,
  output logic [ERR_W-1:0] err
);
  logic [ERR_W-1:0] set_vec, causes, nxt;

  always_comb begin
    set_vec              = '0;
    set_vec[ERR_WR_BIT]  = set_wr;
    set_vec[ERR_RD_BIT]  = set_rd;
    set_vec[ERR_MOD_BIT] = set_mod;
    causes = ((err & ~(clr_we ? clr_mask : '0)) | set_vec) & CAUSE_MASK;
    nxt    = causes;
    nxt[ERR_ANY_BIT] = |causes;
  end

  always_ff @(posedge clk) begin
    if (rst) err <= '0;
    else     err <= nxt;
  end
endmodule

// File: rtl/crypto_acl_guard.sv
module crypto_acl_guard
  import acl_guard_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [IDXW-1:0]  cmd_x,
  input  logic [IDXW-1:0]  cmd_y,
  input  logic [IDXW-1:0]  cmd_key,
  input  logic [ACL_W-1:0] cmd_imm,
  input  logic [ACL_W-1:0] secret_acl,
  input  logic             sig_pass,
  input  logic             secure_mode,
  input  logic             err_clr_we,
  input  logic [ERR_W-1:0] err_clr_mask,
  input  logic [IDXW-1:0]  mon_idx,
  output logic             resp_valid,
  output logic             resp_allow,
  output logic [ERR_W-1:0] acl_err,
  output logic             acl_irq,
  output logic             sig_valid,
  output logic [IDXW-1:0]  sig_idx,
  output logic [ACL_W-1:0] mon_acl
);
  logic [ACL_W-1:0] acl_x, acl_y, acl_k;
  verdict_t         v;

  acl_file #(.NREG(NREG)) u_file (
    .clk     (clk),
    .rst     (rst),
    .we      (cmd_valid & v.wr_en),
    .waddr   (cmd_x),
    .wdata   (v.wr_val),
    .ra      (cmd_x),
    .rb      (cmd_y),
    .rc      (cmd_key),
    .da      (acl_x),
    .db      (acl_y),
    .dc      (acl_k),
    .mon_idx (mon_idx),
    .mon_acl (mon_acl)
  );

  acl_policy u_pol (
    .op          (cmd_op),
    .acl_x       (acl_x),
    .acl_y       (acl_y),
    .acl_k       (acl_k),
    .imm         (cmd_imm),
    .secret_acl  (secret_acl),
    .sig_pass    (sig_pass),
    .secure_mode (secure_mode),
    .sig_valid   (sig_valid),
    .verdict     (v)
  );

  acl_err_reg u_err (
    .clk      (clk),
    .rst      (rst),
    .set_wr   (cmd_valid & v.e_wr),
    .set_rd   (cmd_valid & v.e_rd),
    .set_mod  (cmd_valid & v.e_mod),
    .clr_we   (err_clr_we),
    .clr_mask (err_clr_mask),
    .err      (acl_err)
  );

  assign acl_irq = acl_err[ERR_ANY_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      sig_valid  <= 1'b0;
      sig_idx    <= '0;
    end else begin
      resp_valid <= cmd_valid;
      resp_allow <= cmd_valid & v.allow;
      if (cmd_valid && v.sig_set) begin
        sig_valid <= 1'b1;
        sig_idx   <= cmd_x;
      end else if (cmd_valid && v.sig_clr) begin
        sig_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crypto_acl_guard_chk.sv
module crypto_acl_guard_chk
  import acl_guard_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [OP_W-1:0]  cmd_op,
  input logic             secure_mode,
  input logic             err_clr_we,
  input logic             resp_valid,
  input logic             resp_allow,
  input logic [ERR_W-1:0] acl_err,
  input logic             sig_valid
);
  AST_RESP_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> resp_valid); // R2
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !resp_valid); // R2
  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
    acl_err[ERR_ANY_BIT] == (acl_err[ERR_WR_BIT] | acl_err[ERR_RD_BIT] | acl_err[ERR_MOD_BIT])); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acl_err & ~(CAUSE_MASK | (32'h1 << ERR_ANY_BIT))) == '0); // R10
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (acl_err[ERR_MOD_BIT] && !err_clr_we) |=> acl_err[ERR_MOD_BIT]); // R10
  AST_SIGCLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SIGCLR) |=> !sig_valid); // R8
  AST_SECURE_NO_AUTH: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SIGAUTH && secure_mode) |=> !resp_allow); // R7
  AST_SIGENC_NEEDS_SIG: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SIGENC && !sig_valid) |=> !resp_allow); // R9
endmodule

bind crypto_acl_guard crypto_acl_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .secure_mode (secure_mode),
  .err_clr_we  (err_clr_we),
  .resp_valid  (resp_valid),
  .resp_allow  (resp_allow),
  .acl_err     (acl_err),
  .sig_valid   (sig_valid)
);

// File: tb/tb_crypto_acl_guard.sv
module tb_crypto_acl_guard;
  import acl_guard_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int IDXW = $clog2(NREG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [OP_W-1:0] cmd_op = '0;
  logic [IDXW-1:0] cmd_x = '0, cmd_y = '0, cmd_key = '0, mon_idx = '0;
  logic [ACL_W-1:0] cmd_imm = '0, secret_acl = '0;
  logic sig_pass = 1'b0, secure_mode = 1'b0, err_clr_we = 1'b0;
  logic [ERR_W-1:0] err_clr_mask = '0;
  logic resp_valid, resp_allow, acl_irq, sig_valid;
  logic [ERR_W-1:0] acl_err;
  logic [IDXW-1:0] sig_idx;
  logic [ACL_W-1:0] mon_acl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crypto_acl_guard #(.NREG(NREG)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [4:0] op, int x, int y = 0, int key = 0,
                     logic [4:0] imm = 0, logic [4:0] sacl = 0,
                     bit pass = 0, bit sec = 0, bit clr = 0,
                     logic [31:0] cmask = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_x = x[IDXW-1:0]; cmd_y = y[IDXW-1:0];
    cmd_key = key[IDXW-1:0]; cmd_imm = imm; secret_acl = sacl;
    sig_pass = pass; secure_mode = sec; err_clr_we = clr; err_clr_mask = cmask;
    @(negedge clk);
    cmd_valid = 0; err_clr_we = 0; sig_pass = 0; secure_mode = 0;
  endtask

  task automatic clear_err(logic [31:0] m);
    @(negedge clk);
    err_clr_we = 1; err_clr_mask = m;
    @(negedge clk);
    err_clr_we = 0;
  endtask

  task automatic acl_of(int idx, output logic [4:0] val);
    mon_idx = idx[IDXW-1:0];
    @(negedge clk);
    val = mon_acl;
  endtask

  task automatic t_reset();
    logic [4:0] a;
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 err", acl_err, 0);
    chk("R1 irq", 32'(acl_irq), 0);
    chk("R1 sig_valid", 32'(sig_valid), 0);
    acl_of(0, a); chk("R1 acl0", 32'(a), 0);
    acl_of(7, a); chk("R12 acl7", 32'(a), 0);
  endtask

  task automatic t_load();
    logic [4:0] a;
    cmd(OP_RND, 1);
    chk("R2 resp_valid", 32'(resp_valid), 1);
    chk("R3 rnd allow", 32'(resp_allow), 1);
    acl_of(1, a); chk("R3 rnd acl", 32'(a), 32'h1F);
    cmd(OP_SECRET, 2, .sacl(5'h06));
    acl_of(2, a); chk("R3 secret acl", 32'(a), 32'h06);
    cmd(OP_SECRET, 1, .sacl(5'h0C));
    acl_of(1, a); chk("R3 secret overwrite", 32'(a), 32'h0C);
    chk("R2 idle no resp", 32'(resp_valid), 0);
  endtask

  task automatic t_xor();
    logic [4:0] a;
    cmd(OP_RND, 3);
    cmd(OP_XOR, 3, 2);
    chk("R4 xor allow", 32'(resp_allow), 1);
    chk("R4 xor no err", acl_err, 0);
    acl_of(3, a); chk("R4 xor keeps acl", 32'(a), 32'h1F);
    cmd(OP_XOR, 1, 2);
    chk("R4 xor dst deny", 32'(resp_allow), 0);
    chk("R4 write fault", acl_err, 32'h8000_0001);
    chk("R10 irq", 32'(acl_irq), 1);
    clear_err(32'h1);
    chk("R10 w1c", acl_err, 0);
    cmd(OP_XOR, 3, 1);
    chk("R4 read fault", acl_err, 32'h8000_0010);
    cmd(OP_XOR, 1, 1);
    chk("R10 sticky accumulate", acl_err, 32'h8000_0011);
    clear_err(32'h8000_0000);
    chk("R10 summary follows causes", acl_err, 32'h8000_0011);
    clear_err(32'hFFFF_FFFF);
    chk("R10 clear all", acl_err, 0);
    chk("R10 irq low", 32'(acl_irq), 0);
  endtask

  task automatic t_chmod();
    logic [4:0] a;
    cmd(OP_CHMOD, 3, .imm(5'h03));
    chk("R5 narrow allow", 32'(resp_allow), 1);
    acl_of(3, a); chk("R5 narrow acl", 32'(a), 32'h03);
    cmd(OP_CHMOD, 3, .imm(5'h07));
    chk("R5 widen deny", 32'(resp_allow), 0);
    chk("R5 mod fault", acl_err, 32'h8000_0100);
    acl_of(3, a); chk("R5 acl kept", 32'(a), 32'h03);
    clear_err(32'hFFFF_FFFF);
    cmd(OP_CHMOD, 3, .imm(5'h10), .clr(1), .cmask(32'hFFFF_FFFF));
    chk("R10 set beats clear", acl_err, 32'h8000_0100);
    clear_err(32'hFFFF_FFFF);
  endtask

  task automatic t_cipher();
    logic [4:0] a;
    cmd(OP_SECRET, 4, .sacl(5'h1A));
    cmd(OP_RND, 5);
    cmd(OP_CHMOD, 5, .imm(5'h0E));
    cmd(OP_DEC, 6, 4, 5);
    chk("R6 dec allow", 32'(resp_allow), 1);
    acl_of(6, a); chk("R6 dec acl", 32'(a), 32'h0A);
    cmd(OP_ENC, 7, 3, 5);
    acl_of(7, a); chk("R6 enc acl", 32'(a), 32'h02);
  endtask

  task automatic t_sig();
    logic [4:0] a;
    cmd(OP_SIGENC, 0);
    chk("R9 no sig deny", 32'(resp_allow), 0);
    chk("R9 no err", acl_err, 0);
    acl_of(0, a); chk("R9 acl kept", 32'(a), 0);
    cmd(OP_SIGAUTH, 5, .pass(1), .sec(1));
    chk("R7 secure deny", 32'(resp_allow), 0);
    chk("R7 secure no flag", 32'(sig_valid), 0);
    cmd(OP_SIGAUTH, 2, .pass(0));
    chk("R7 allow", 32'(resp_allow), 1);
    chk("R7 fail no flag", 32'(sig_valid), 0);
    cmd(OP_SIGAUTH, 5, .pass(1));
    chk("R7 pass flag", 32'(sig_valid), 1);
    chk("R7 sig idx", 32'(sig_idx), 5);
    cmd(OP_SIGENC, 0);
    chk("R9 sigenc allow", 32'(resp_allow), 1);
    acl_of(0, a); chk("R9 sigenc acl", 32'(a), 32'h13);
    cmd(OP_SIGCLR, 0);
    chk("R8 clr allow", 32'(resp_allow), 1);
    chk("R8 flag cleared", 32'(sig_valid), 0);
    cmd(OP_SIGENC, 1);
    chk("R9 after clr deny", 32'(resp_allow), 0);
    acl_of(1, a); chk("R9 after clr acl", 32'(a), 32'h0C);
  endtask

  task automatic t_misc();
    logic [4:0] a;
    cmd(5'h09, 1, 1, .imm(5'h1F));
    chk("R11 unknown deny", 32'(resp_allow), 0);
    chk("R11 unknown no err", acl_err, 0);
    acl_of(1, a); chk("R11 unknown acl kept", 32'(a), 32'h0C);
    cmd(OP_NOP, 0);
    chk("R11 nop allow", 32'(resp_allow), 1);
    @(negedge clk);
    chk("R2 no cmd no resp", 32'(resp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_load();
    t_xor();
    t_chmod();
    t_cipher();
    t_sig();
    t_misc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule